// File: doc/BRIEF.md
# Programmable Column-Truncated Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns the full 2N-bit product. Its sign handling rests on a Baugh-Wooley arrangement: every partial product bit is positive, the bits of the two sign rows are inverted, and two fixed one bits restore the correct signed result. The partial product bits feed a carry-save reduction and then one exact carry-propagate adder.

A run-time enable vector has one bit per product column, so it holds 2N-1 bits. Each partial product bit is a three-input AND of its two operand bits and the enable bit of its column i+j. Clearing an enable bit forces every term in that column to zero, so those gates stop toggling. The cost is accuracy in the low part of the product. The two correction constants are never gated. With every enable set, the block is an exact signed multiplier. A DSP datapath sets the enable vector to trade precision for switching activity while it runs.

The block is purely combinational, with no clock and no handshake. Its operand and enable inputs are plain levels, and the product follows them.

Top module: `ptm_mult`

## Requirements
- R1: When every bit of `col_en` is 1, `prod` equals the signed product op_a × op_b, taken modulo 2^(2N), for all operand values.
- R2: When `col_en` is all zeros, `prod` equals 2^N + 2^(2N-1) for any operands. For N=8 this is 0x8100. The correction constants are never gated.
- R3: For i ≤ N-2 and j ≤ N-2, partial product [i,j] is op_a[i] AND op_b[j] AND col_en[i+j], at weight 2^(i+j). For N=8, col_en=0x0001 with op_a=op_b=0x01 gives 0x8101.
- R4: When exactly one of i or j equals N-1, partial product [i,j] is NOT(op_a[i] AND op_b[j]) AND col_en[i+j]. For N=8, col_en=0x2000 gives 0xC100 for op_a=op_b=0x00 and 0x8100 for op_a=op_b=0xFF.
- R5: Partial product [N-1,N-1] is op_a[N-1] AND op_b[N-1] AND col_en[2N-2], with no inversion. For N=8, col_en=0x4000 gives 0xC100 for op_a=op_b=0x80.
- R6: For any `col_en`, `prod` equals the sum of the enabled partial products at weight 2^(i+j), plus 2^N and 2^(2N-1), taken modulo 2^(2N).
- R7: For N=8 with col_en=0x7F00, columns 0 to 7 contribute nothing. Operand bit 0 of either input then has no effect on `prod`, and op_a=op_b=0 gives 0xFF00.
- R8: The parameter N can take any value from 4 to 16, and the width of `col_en` is 2N-1. At N=16 with all enables set, the block gives the exact signed 32-bit product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | Multiplicand, two's complement |
| op_b | input | N | Multiplier, two's complement |
| col_en | input | 2N-1 | Column enables; bit c gates every partial product of weight 2^c |
| prod | output | 2N | Product, modulo 2^(2N) |

## Verification
The bench builds three instances, at N=8, N=4 and N=16. At N=8 with full enables, every one of the 65536 operand pairs is compared with the signed product, and directed enable patterns isolate the plain, inverted-sign and corner terms. At N=4 every enable vector is run against every operand pair, which covers every partial truncation pattern against a summing model. At N=16 a pseudo-random set of operands and enables checks the largest width against both the exact product and the model.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  localparam int unsigned PTM_MIN_W = 4;
  localparam int unsigned PTM_MAX_W = 16;

  // Kind of partial product term by its position in the matrix
  typedef enum logic [1:0] {
    TERM_PLAIN,
    TERM_MIXED,
    TERM_CORNER
  } term_kind_e;

  function automatic term_kind_e kind_of(input int i, input int j, input int n);
    if (i == n - 1 && j == n - 1) return TERM_CORNER;
    if (i == n - 1 || j == n - 1) return TERM_MIXED;
    return TERM_PLAIN;
  endfunction

endpackage

// File: rtl/ptm_ppgen.sv
module ptm_ppgen
  import ptm_pkg::*;
#(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int TW = 2 * N - 1
) (
  input  logic [N-1:0]        mcand,
  input  logic [N-1:0]        mplier,
  input  logic [TW-1:0]       col_en,
  output logic [N-1:0][W-1:0] rows
);

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gb = 0; gb < W; gb++) begin : g_bit
      if (gb >= gi && gb < gi + N) begin : g_term
        localparam int J = gb - gi;
        localparam term_kind_e K = kind_of(gi, J, N);
        if (K == TERM_MIXED) begin : g_mixed
          assign rows[gi][gb] = col_en[gb] & ~(mcand[gi] & mplier[J]);
        end else begin : g_pos
          assign rows[gi][gb] = col_en[gb] & mcand[gi] & mplier[J];
        end
        // A disabled column must carry no active term (R3, R4, R5)
        always_comb begin
          assert_col_gate_R3: assert (col_en[gb] || !rows[gi][gb])
            else $error("gated column %0d carries a one", gb);
        end
      end else begin : g_pad
        assign rows[gi][gb] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/ptm_csa.sv
module ptm_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  assign carry_o[0] = 1'b0;

  for (genvar gb = 0; gb < W; gb++) begin : g_fa
    assign sum_o[gb] = in_a[gb] ^ in_b[gb] ^ in_c[gb];
    if (gb < W - 1) begin : g_cy
      assign carry_o[gb+1] = (in_a[gb] & in_b[gb]) | (in_a[gb] & in_c[gb]) | (in_b[gb] & in_c[gb]);
    end
  end

  // The compressor keeps the arithmetic value of its three inputs (R6)
  always_comb begin
    assert_csa_keeps_sum_R6: assert (W'(sum_o + carry_o) == W'(in_a + in_b + in_c))
      else $error("carry-save stage lost value");
  end

endmodule

// File: rtl/ptm_cpa.sv
module ptm_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] cy;

  assign cy[0] = 1'b0;

  for (genvar gb = 0; gb < W; gb++) begin : g_rip
    assign sum_o[gb] = in_a[gb] ^ in_b[gb] ^ cy[gb];
    if (gb < W - 1) begin : g_cy
      assign cy[gb+1] = (in_a[gb] & in_b[gb]) | (cy[gb] & (in_a[gb] ^ in_b[gb]));
    end
  end

  // The final adder is exact modulo 2^W (R6)
  always_comb begin
    assert_cpa_exact_R6: assert (sum_o == W'(in_a + in_b))
      else $error("final adder mismatch");
  end

endmodule

// File: rtl/ptm_mult.sv
module ptm_mult #(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int TW = 2 * N - 1,
  localparam int STAGES = N - 1
) (
  input  logic [N-1:0]  op_a,
  input  logic [N-1:0]  op_b,
  input  logic [TW-1:0] col_en,
  output logic [W-1:0]  prod
);

  localparam logic [W-1:0] BW_CONST = (W'(1) << N) | (W'(1) << (W - 1));

  logic [N-1:0][W-1:0]      rows;
  logic [N:0][W-1:0]        opnd;
  logic [STAGES-1:0][W-1:0] s_chain;
  logic [STAGES-1:0][W-1:0] c_chain;

  ptm_ppgen #(.N(N)) u_ppgen (
    .mcand  (op_a),
    .mplier (op_b),
    .col_en (col_en),
    .rows   (rows)
  );

  for (genvar gr = 0; gr < N; gr++) begin : g_opnd
    assign opnd[gr] = rows[gr];
  end
  assign opnd[N] = BW_CONST;

  for (genvar gk = 0; gk < STAGES; gk++) begin : g_stage
    if (gk == 0) begin : g_first
      ptm_csa #(.W(W)) u_csa (
        .in_a    (opnd[0]),
        .in_b    (opnd[1]),
        .in_c    (opnd[2]),
        .sum_o   (s_chain[0]),
        .carry_o (c_chain[0])
      );
    end else begin : g_next
      ptm_csa #(.W(W)) u_csa (
        .in_a    (s_chain[gk-1]),
        .in_b    (c_chain[gk-1]),
        .in_c    (opnd[gk+2]),
        .sum_o   (s_chain[gk]),
        .carry_o (c_chain[gk])
      );
    end
  end

  ptm_cpa #(.W(W)) u_cpa (
    .in_a  (s_chain[STAGES-1]),
    .in_b  (c_chain[STAGES-1]),
    .sum_o (prod)
  );

  logic [W-1:0] sx_ext;
  logic [W-1:0] sy_ext;
  assign sx_ext = {{N{op_a[N-1]}}, op_a};
  assign sy_ext = {{N{op_b[N-1]}}, op_b};

  always_comb begin
    // Full enables give the exact signed product (R1)
    assert_exact_product_R1: assert (!(&col_en) || prod == W'(sx_ext * sy_ext))
      else $error("full-enable product wrong");
    // No enables leave only the correction constants (R2)
    assert_constants_only_R2: assert ((|col_en) || prod == BW_CONST)
      else $error("all-off product wrong");
  end

endmodule

// File: tb/ptm_mult_tb_top.sv
module ptm_mult_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0]  a8, b8;
  logic [14:0] t8;
  logic [15:0] p8;
  logic [3:0]  a4, b4;
  logic [6:0]  t4;
  logic [7:0]  p4;
  logic [15:0] a16, b16;
  logic [30:0] t16;
  logic [31:0] p16;

  ptm_mult #(.N(8))  dut_i     (.op_a(a8),  .op_b(b8),  .col_en(t8),  .prod(p8));
  ptm_mult #(.N(4))  dut_n4_i  (.op_a(a4),  .op_b(b4),  .col_en(t4),  .prod(p4));
  ptm_mult #(.N(16)) dut_n16_i (.op_a(a16), .op_b(b16), .col_en(t16), .prod(p16));

  // {op_a, op_b, expected} at N=8 with every column enabled
  localparam logic [31:0] R1_VEC [8] = '{
    {8'h7F, 8'h7F, 16'h3F01},
    {8'h80, 8'h80, 16'h4000},
    {8'h80, 8'h7F, 16'hC080},
    {8'hFF, 8'hFF, 16'h0001},
    {8'hFF, 8'h01, 16'hFFFF},
    {8'h00, 8'h5A, 16'h0000},
    {8'h12, 8'h34, 16'h03A8},
    {8'hF6, 8'h0D, 16'hFF7E}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input int n, input logic [63:0] a,
                                        input logic [63:0] b, input logic [63:0] t);
    logic [63:0] acc = 64'd0;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < n; j++) begin
        logic term;
        if (i == n - 1 && j == n - 1) term = a[i] & b[j];
        else if (i == n - 1 || j == n - 1) term = ~(a[i] & b[j]);
        else term = a[i] & b[j];
        if (t[i+j] && term) acc = acc + (64'd1 << (i + j));
      end
    end
    acc = acc + (64'd1 << n) + (64'd1 << (2 * n - 1));
    return acc & ((64'd1 << (2 * n)) - 64'd1);
  endfunction

  task automatic run8(input logic [7:0] a, input logic [7:0] b, input logic [14:0] t);
    @(negedge clk);
    a8 = a; b8 = b; t8 = t;
    #2;
  endtask

  initial begin
    a8 = '0; b8 = '0; t8 = '0;
    a4 = '0; b4 = '0; t4 = '0;
    a16 = '0; b16 = '0; t16 = '0;
    repeat (3) @(posedge clk);
    #2;
    // Reset-time state: all enables off leaves the constants (R2)
    check("R2 reset", {48'd0, p8}, 64'h8100);
    rst_n = 1'b1;

    foreach (R1_VEC[k]) begin
      run8(R1_VEC[k][31:24], R1_VEC[k][23:16], 15'h7FFF);
      check("R1 table", {48'd0, p8}, {48'd0, R1_VEC[k][15:0]});
    end

    for (int v = 0; v < 65536; v++) begin
      logic [15:0] sx, sy;
      run8(v[15:8], v[7:0], 15'h7FFF);
      sx = {{8{v[15]}}, v[15:8]};
      sy = {{8{v[7]}}, v[7:0]};
      check("R1 exhaustive", {48'd0, p8}, {48'd0, 16'(sx * sy)});
    end

    run8(8'h5A, 8'hA5, 15'h0000); check("R2", {48'd0, p8}, 64'h8100);
    run8(8'hFF, 8'h80, 15'h0000); check("R2", {48'd0, p8}, 64'h8100);
    run8(8'h01, 8'h01, 15'h0001); check("R3", {48'd0, p8}, 64'h8101);
    run8(8'h03, 8'h01, 15'h0002); check("R3", {48'd0, p8}, 64'h8102);
    run8(8'h00, 8'h00, 15'h2000); check("R4", {48'd0, p8}, 64'hC100);
    run8(8'hFF, 8'hFF, 15'h2000); check("R4", {48'd0, p8}, 64'h8100);
    run8(8'h80, 8'h80, 15'h4000); check("R5", {48'd0, p8}, 64'hC100);
    run8(8'h80, 8'h00, 15'h4000); check("R5", {48'd0, p8}, 64'h8100);
    run8(8'h00, 8'h00, 15'h7F00); check("R7", {48'd0, p8}, 64'hFF00);
    run8(8'h01, 8'h01, 15'h7F00); check("R7", {48'd0, p8}, 64'hFF00);
    begin
      logic [15:0] ref_p;
      run8(8'h5A, 8'h36, 15'h7F00);
      ref_p = p8;
      check("R7 model", {48'd0, p8}, model(8, 64'h5A, 64'h36, 64'h7F00));
      run8(8'h5B, 8'h37, 15'h7F00);
      check("R7 bit0 ignored", {48'd0, p8}, {48'd0, ref_p});
    end

    for (int v = 0; v < 32768; v++) begin
      @(negedge clk);
      t4 = v[14:8]; a4 = v[7:4]; b4 = v[3:0];
      #2;
      check("R6 n4", {56'd0, p4}, model(4, {60'd0, v[7:4]}, {60'd0, v[3:0]}, {57'd0, v[14:8]}));
    end

    begin
      logic [63:0] st = 64'h9E3779B97F4A7C15;
      for (int k = 0; k < 400; k++) begin
        st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
        @(negedge clk);
        a16 = st[15:0]; b16 = st[31:16];
        t16 = (k % 4 == 0) ? 31'h7FFFFFFF : st[62:32];
        #2;
        if (k % 4 == 0) begin
          logic [31:0] ex, ey;
          ex = {{16{a16[15]}}, a16};
          ey = {{16{b16[15]}}, b16};
          check("R8 n16 exact", {32'd0, p16}, {32'd0, 32'(ex * ey)});
        end else begin
          check("R6 n16", {32'd0, p16}, model(16, {48'd0, a16}, {48'd0, b16}, {33'd0, t16}));
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule